// File: doc/BRIEF.md
# Redundant-Sum Fixed-Coefficient FIR Filter

This block is a transposed-form FIR filter whose coefficients are fixed when the design is built. A strobe marks each two's-complement input sample. The filter gives one filtered result per accepted sample. Each coefficient is supplied already recoded into signed digits, as two masks: one holds the digits worth +1 and the other holds the digits worth -1.

Inside the tap chain, no partial sum is ever resolved to binary. Every running sum is kept as three vectors of equal weight, so each digit position has three bits. In each tap, one layer of 6-input/3-output bit counters turns the six signed-digit partial products into a three-vector product. A second counter layer then merges that product with the three-vector sum coming from the next tap. A single carry-propagate addition happens only after tap 0, and that result is registered as the output.

Top module: `fir_rds_top`

## Requirements
- R1: A synchronous active-high `rst` clears every tap register, `out_valid` and `out_sample` to zero. No sample accepted before a reset has any effect on results after it.
- R2: After a cycle with `in_valid` high, `out_sample` equals the sum over k of c[k]·x[n-k], taken modulo 2^OUT_W in two's complement. Here x[n] is the sample just accepted and x[n-k] is the sample accepted k strobes earlier, counting zero for any strobe before reset.
- R3: `out_valid` is high in exactly those cycles that follow a cycle in which `in_valid` was high. This gives a latency of one clock.
- R4: A cycle with `in_valid` low leaves all tap state and `out_sample` unchanged. The `in_sample` value presented in such a cycle never reaches any later result.
- R5: When a single sample of value 1 follows reset and is followed by zero samples, the outputs are c[0], c[1], …, c[TAPS-1] in that order, and after that zero.
- R6: Coefficient c[k] is the sum over j of 2^j·POS[k][j] minus the sum over j of 2^j·NEG[k][j]. The two masks of a tap share no set bit, and together they hold at most six set bits.
- R7: OUT_W defaults to DATA_W + COEF_W + ceil(log2(TAPS)). With this width no input sequence can make the result wrap, including sustained most-negative samples and inputs whose signs match the coefficient signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_sample` as a sample to accept |
| in_sample | input | DATA_W | Two's-complement input sample |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| out_sample | output | OUT_W | Two's-complement filter result |

## Verification
The properties take for granted that `rst` is high on the first clock edge and that `in_valid` never carries an unknown value. The bench meets both: it drives every input from the start and asserts reset before any edge. The arithmetic depends on the coefficient masks obeying R6. The default masks are checked against that rule at the start of the run, and all stimulus samples stay within DATA_W bits, so the sizing argument of R7 applies to every vector.

// File: rtl/fir_rds_pkg.sv
package fir_rds_pkg;

    // Default geometry.
    localparam int DEF_TAPS   = 25;
    localparam int DEF_DATA_W = 12;
    localparam int DEF_COEF_W = 12;

    // Bit counter shape: six same-weight inputs in, three weighted bits out.
    localparam int SLOTS = 6;
    // Number of equal-weight vectors carried by a redundant sum.
    localparam int LANES = 3;

    // Default coefficient set, recoded into signed digits.
    // Each row: tap 24 first. The set is symmetric, so the order reads the same either way.
    localparam logic [DEF_TAPS-1:0][DEF_COEF_W-1:0] DEF_POS = {
        12'h004, 12'h008, 12'h010, 12'h000, 12'h040, 12'h080, 12'h100,
        12'h000, 12'h200, 12'h400, 12'h802, 12'h800, 12'h820, 12'h800,
        12'h802, 12'h400, 12'h200, 12'h000, 12'h100, 12'h080, 12'h040,
        12'h000, 12'h010, 12'h008, 12'h004
    };
    localparam logic [DEF_TAPS-1:0][DEF_COEF_W-1:0] DEF_NEG = {
        12'h001, 12'h000, 12'h002, 12'h014, 12'h008, 12'h021, 12'h012,
        12'h050, 12'h044, 12'h090, 12'h100, 12'h024, 12'h005, 12'h024,
        12'h100, 12'h090, 12'h044, 12'h050, 12'h012, 12'h021, 12'h008,
        12'h014, 12'h002, 12'h000, 12'h001
    };

endpackage

// File: rtl/rds_ctr63.sv
module rds_ctr63
    import fir_rds_pkg::*;
(
    input  logic [SLOTS-1:0] bits_i,
    output logic [2:0]       cnt_o
);

    // Population count of six same-weight bits.
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < SLOTS; i++) begin
            cnt_o = cnt_o + {2'b00, bits_i[i]};
        end
    end

endmodule

// File: rtl/rds_layer.sv
module rds_layer
    import fir_rds_pkg::*;
#(
    parameter int W = 29
) (
    input  logic [SLOTS-1:0][W-1:0] vec_i,
    output logic [LANES-1:0][W-1:0] vec_o
);

    logic [W-1:0] ones_w;
    logic [W-1:0] twos_w;
    logic [W-1:0] fours_w;

    // One counter per bit column; no carry crosses columns inside the layer.
    for (genvar b = 0; b < W; b++) begin : g_col
        logic [SLOTS-1:0] col;
        logic [2:0]       cnt;
        for (genvar s = 0; s < SLOTS; s++) begin : g_pick
            assign col[s] = vec_i[s][b];
        end
        rds_ctr63 u_ctr (
            .bits_i (col),
            .cnt_o  (cnt)
        );
        assign ones_w[b]  = cnt[0];
        assign twos_w[b]  = cnt[1];
        assign fours_w[b] = cnt[2];
    end

    // Re-weight the count bits; anything above bit W-1 is dropped (mod 2^W).
    assign vec_o[0] = ones_w;
    assign vec_o[1] = {twos_w[W-2:0], 1'b0};
    assign vec_o[2] = {fours_w[W-3:0], 2'b00};

    logic unused_hi;
    assign unused_hi = ^{twos_w[W-1], fours_w[W-1:W-2]};

endmodule

// File: rtl/fir_rds_tap.sv
module fir_rds_tap
    import fir_rds_pkg::*;
#(
    parameter int              W      = 29,
    parameter int              COEF_W = 12,
    parameter logic [COEF_W-1:0] POS  = '0,
    parameter logic [COEF_W-1:0] NEG  = '0
) (
    input  logic [W-1:0]            xp_i,   // sample, sign-extended
    input  logic [W-1:0]            xn_i,   // negated sample, sign-extended
    input  logic [LANES-1:0][W-1:0] acc_i,  // redundant sum from the next tap
    output logic [LANES-1:0][W-1:0] acc_o   // redundant sum for this tap
);

    logic [SLOTS-1:0][W-1:0]  pp;
    logic [LANES-1:0][W-1:0]  prod;
    logic [SLOTS-1:0][W-1:0]  merge;

    // Place one shifted copy of the sample per nonzero signed digit.
    always_comb begin
        int slot;
        pp   = '0;
        slot = 0;
        for (int j = 0; j < COEF_W; j++) begin
            if (POS[j] && slot < SLOTS) begin
                pp[slot] = xp_i << j;
                slot     = slot + 1;
            end else if (NEG[j] && slot < SLOTS) begin
                pp[slot] = xn_i << j;
                slot     = slot + 1;
            end
        end
    end

    // Layer one: product as three vectors.
    rds_layer #(.W(W)) u_mul (
        .vec_i (pp),
        .vec_o (prod)
    );

    // Layer two: product plus incoming running sum.
    assign merge = {acc_i, prod};

    rds_layer #(.W(W)) u_acc (
        .vec_i (merge),
        .vec_o (acc_o)
    );

endmodule

// File: rtl/fir_rds_top.sv
module fir_rds_top
    import fir_rds_pkg::*;
#(
    parameter int TAPS   = DEF_TAPS,
    parameter int DATA_W = DEF_DATA_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int OUT_W  = DATA_W + COEF_W + $clog2(TAPS),
    parameter logic [TAPS-1:0][COEF_W-1:0] COEF_POS = DEF_POS,
    parameter logic [TAPS-1:0][COEF_W-1:0] COEF_NEG = DEF_NEG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_sample
);

    localparam int EXT_W = OUT_W - DATA_W;

    typedef struct packed {
        logic [TAPS-1:1][LANES-1:0][OUT_W-1:0] tap;
        logic [OUT_W-1:0]                      y;
        logic                                  vld;
    } state_t;

    state_t st_d, st_q;

    logic [OUT_W-1:0] xp;
    logic [OUT_W-1:0] xn;

    logic [TAPS-1:0][LANES-1:0][OUT_W-1:0] tap_in;
    logic [TAPS-1:0][LANES-1:0][OUT_W-1:0] tap_res;

    // Sample and its negation, shared by all taps (outside the tap chain).
    assign xp = {{EXT_W{in_sample[DATA_W-1]}}, in_sample};
    assign xn = '0 - xp;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == TAPS - 1) begin : g_last
            assign tap_in[k] = '0;
        end else begin : g_mid
            assign tap_in[k] = st_q.tap[k+1];
        end

        fir_rds_tap #(
            .W      (OUT_W),
            .COEF_W (COEF_W),
            .POS    (COEF_POS[k]),
            .NEG    (COEF_NEG[k])
        ) u_tap (
            .xp_i  (xp),
            .xn_i  (xn),
            .acc_i (tap_in[k]),
            .acc_o (tap_res[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            for (int k = 1; k < TAPS; k++) begin
                st_d.tap[k] = tap_res[k];
            end
            // The only carry-propagate addition: resolve tap 0.
            st_d.y = tap_res[0][0] + tap_res[0][1] + tap_res[0][2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_sample = st_q.y;

endmodule

// File: rtl/fir_rds_chk.sv
module fir_rds_chk #(
    parameter int W = 29
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_sample
);

    logic armed_q;
    logic was_rst_q;

    always_ff @(posedge clk) begin
        was_rst_q <= rst;
        if (rst) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        was_rst_q |-> (!out_valid && out_sample == '0));

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (out_valid == $past(in_valid)));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !$past(in_valid)) |-> $stable(out_sample));

    // R4
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !out_valid) |-> $stable(out_sample));

endmodule

bind fir_rds_top fir_rds_chk #(.W(OUT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/tb_fir_rds_top.sv
module tb_fir_rds_top;
    import fir_rds_pkg::*;

    localparam int TAPS   = DEF_TAPS;
    localparam int DATA_W = DEF_DATA_W;
    localparam int OUT_W  = DEF_DATA_W + DEF_COEF_W + $clog2(DEF_TAPS);
    localparam int NVEC   = 20;

    // Stimulus table: {valid, sample}; expected values come from the model.
    localparam logic [DATA_W:0] VEC [NVEC] = '{
        13'h1_7FF, 13'h1_800, 13'h0_555, 13'h1_001, 13'h1_FFF,
        13'h0_7FF, 13'h0_800, 13'h1_3A5, 13'h1_C5A, 13'h0_123,
        13'h1_000, 13'h1_0F0, 13'h1_F0F, 13'h0_FFF, 13'h1_400,
        13'h1_BFF, 13'h1_7FE, 13'h1_801, 13'h0_2AA, 13'h1_0AA
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_sample = '0;
    logic              out_valid;
    logic [OUT_W-1:0]  out_sample;

    int errors = 0;
    int checks = 0;
    longint hist [TAPS];

    always #5 clk = ~clk;

    fir_rds_top dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    function automatic longint coef(int k);
        longint p, n;
        p = {52'd0, DEF_POS[k]};
        n = {52'd0, DEF_NEG[k]};
        return p - n;
    endfunction

    function automatic logic [OUT_W-1:0] model_y();
        logic signed [63:0] acc;
        acc = 0;
        for (int k = 0; k < TAPS; k++) acc += coef(k) * hist[k];
        return acc[OUT_W-1:0];
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
    endtask

    // Entered at a negedge; returns at the next negedge with outputs checked.
    task automatic push(input logic v, input logic [DATA_W-1:0] s, input string req);
        logic [OUT_W-1:0] prev_y;
        prev_y    = out_sample;
        in_valid  = v;
        in_sample = s;
        @(negedge clk);
        if (v) begin
            for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'($signed(s));
        end
        check({63'd0, out_valid}, {63'd0, v}, "R3 valid latency");
        if (v) check({35'd0, out_sample}, {35'd0, model_y()}, req);
        else   check({35'd0, out_sample}, {35'd0, prev_y}, "R4 hold on idle cycle");
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_model();
        check({63'd0, out_valid}, 64'd0, "R1 out_valid after reset");
        check({35'd0, out_sample}, 64'd0, "R1 out_sample after reset");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        clear_model();
        @(negedge clk);
        do_reset();

        // R6: masks disjoint, at most six signed digits per tap
        for (int k = 0; k < TAPS; k++) begin
            check({63'd0, ($countones(DEF_POS[k] & DEF_NEG[k]) == 0 &&
                           $countones(DEF_POS[k] | DEF_NEG[k]) <= SLOTS)},
                  64'd1, "R6 coefficient mask rule");
        end

        // R5: impulse response reproduces coefficients in order
        push(1'b1, 12'h001, "R5 impulse tap 0");
        check({35'd0, out_sample}, {35'd0, coef(0)}[34:0] & {{35{1'b0}}, {OUT_W{1'b1}}}, "R5 c0 value");
        for (int k = 1; k < TAPS; k++) begin
            push(1'b1, 12'h000, "R5 impulse tail");
            check({35'd0, out_sample}, {35'd0, coef(k)}[34:0] & {{35{1'b0}}, {OUT_W{1'b1}}}, "R5 ck value");
        end
        push(1'b1, 12'h000, "R5 response ends");
        check({35'd0, out_sample}, 64'd0, "R5 zero after last tap");

        // R2 / R3 / R4: table walk with mixed strobes
        for (int i = 0; i < NVEC; i++) begin
            push(VEC[i][DATA_W], VEC[i][DATA_W-1:0], "R2 table vector");
        end

        // R1: mid-run reset leaves no residue
        do_reset();
        push(1'b1, 12'h001, "R1 no residue after reset");
        check({35'd0, out_sample}, {35'd0, coef(0)}[34:0] & {{35{1'b0}}, {OUT_W{1'b1}}}, "R1 first output");

        // R7: sustained most-negative input
        do_reset();
        for (int k = 0; k < TAPS; k++) push(1'b1, 12'h800, "R7 most negative fill");
        // R7: signs matched to coefficients, oldest first
        for (int k = TAPS - 1; k >= 0; k--) begin
            push(1'b1, (coef(k) >= 0) ? 12'h7FF : 12'h800, "R7 worst-case magnitude");
        end
        for (int k = TAPS - 1; k >= 0; k--) begin
            push(1'b1, (coef(k) >= 0) ? 12'h800 : 12'h7FF, "R7 worst-case negative");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule